// File: doc/BRIEF.md
# Segmented Physical Address Generator

This is a purely combinational address unit for a 16-bit processor that uses segmented real-mode addressing. For each memory reference it forms a 16-bit effective offset. The offset comes from the pointer registers, the instruction pointer, the stack pointer or a displacement, depending on the selected addressing mode. The unit also picks the segment register that applies and produces the 20-bit physical address as the segment shifted left by four bits plus the offset. The sum wraps past the top of the 1 MiB space.

Register values arrive as inputs from the surrounding core. The mode and two pointer selects say which registers take part. The unit applies the implicit segment rules: a BP base implies SS, and everything else implies DS. An override input can replace the segment for data references. Register and immediate modes make no memory reference and raise `noAccess`. Combinations of pointer registers that cannot be encoded raise `illegal`, and in that case the address outputs are forced to zero.

Top module: `seg_addr_gen`

## Requirements
- R1: `physAddr` equals (segment × 16 + effective offset) modulo 2^20; for example, segment FF59 with offset FFFF gives 0F58F.
- R2: The effective offset is the sum of its terms modulo 2^16. When `dispShort` is 1, the displacement is `dispIn[7:0]` sign-extended to 16 bits; otherwise it is all of `dispIn`.
- R3: Mode codes are: 0 register, 1 immediate, 2 direct, 3 register-indirect, 4 based, 5 indexed, 6 based-indexed, 7 instruction fetch and 8 stack. Modes 0 and 1 raise `noAccess` and drive `effOffset`, `segValue` and `physAddr` to zero.
- R4: Register-indirect mode uses `ptrA` as the offset, with pointer codes BX=0, BP=1, SI=2, DI=3. BX, SI and DI select DS, and BP is illegal.
- R5: Based mode adds the displacement to `ptrA`, which must be BX (giving DS) or BP (giving SS); SI or DI is illegal.
- R6: Indexed mode adds the displacement to `ptrA`, which must be SI or DI, giving DS; BX or BP is illegal.
- R7: Based-indexed mode adds `ptrA`, `ptrB` and the displacement. Exactly one of the two selects must be a base (BX/BP) and the other an index (SI/DI), in either order. The segment follows the base register. Two index registers, or two base registers, are illegal.
- R8: Direct mode uses the displacement alone as the offset, with DS.
- R9: Fetch mode gives CS:IP and stack mode gives SS:SP. Both ignore the override and the displacement.
- R10: When `ovrEn` is 1 in modes 2 to 6, `ovrSel` replaces the default segment.
- R11: An illegal combination, including any mode code from 9 to 15, raises `illegal`, clears `memValid` and drives `effOffset`, `segValue` and `physAddr` to zero.
- R12: Segment codes are CS=0, DS=1, ES=2, SS=3. `segUsed` and `segValue` report the chosen segment while `memValid` is 1. Exactly one of `memValid`, `noAccess` and `illegal` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| segCs | input | 16 | Code segment value |
| segDs | input | 16 | Data segment value |
| segEs | input | 16 | Extra segment value |
| segSs | input | 16 | Stack segment value |
| regBx | input | 16 | Base register BX |
| regBp | input | 16 | Base register BP |
| regSi | input | 16 | Index register SI |
| regDi | input | 16 | Index register DI |
| regIp | input | 16 | Instruction pointer |
| regSp | input | 16 | Stack pointer |
| dispIn | input | 16 | Displacement or direct offset |
| dispShort | input | 1 | 1: sign-extend the low 8 bits of `dispIn` |
| modeSel | input | 4 | Addressing mode code (R3) |
| ptrA | input | 2 | First pointer register select |
| ptrB | input | 2 | Second pointer register select (based-indexed only) |
| ovrEn | input | 1 | Segment override enable |
| ovrSel | input | 2 | Override segment code (R12) |
| effOffset | output | 16 | Effective offset |
| segUsed | output | 2 | Chosen segment code |
| segValue | output | 16 | Chosen segment value |
| physAddr | output | 20 | Physical address |
| memValid | output | 1 | A legal memory reference is formed |
| noAccess | output | 1 | Register or immediate mode |
| illegal | output | 1 | Illegal register/mode combination |

## Verification
Every mode code is tried with random register contents, random pointer pairs, random override settings and random displacements of both widths. This separates wrong segment defaults from wrong offset sums, and legal pointer pairs from illegal ones. Directed vectors fix the values that random draws rarely hit: segment FF59 with offset FFFF for the 20-bit wrap, BX=FFFF plus 2 for the 16-bit wrap, displacement 80 in short form for sign extension, and BP-based accesses with and without a CS override. Swapped base/index order and the SI+DI pair are each checked, so an order-sensitive decoder or a missing illegal case shows up as a mismatch.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    M_REG = 4'd0, M_IMM = 4'd1, M_DIRECT = 4'd2, M_INDIR = 4'd3,
    M_BASED = 4'd4, M_INDEXED = 4'd5, M_BASEIDX = 4'd6,
    M_FETCH = 4'd7, M_STACK = 4'd8
  } mode_e;

  typedef enum logic [1:0] {P_BX = 2'd0, P_BP = 2'd1, P_SI = 2'd2, P_DI = 2'd3} ptr_e;
  typedef enum logic [1:0] {S_CS = 2'd0, S_DS = 2'd1, S_ES = 2'd2, S_SS = 2'd3} seg_e;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic       useA;
    logic       useB;
    logic       useDisp;
    logic       fromIp;
    logic       fromSp;
    logic [1:0] segId;
    logic       illegal;
    logic       noAccess;
  } agu_ctrl_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic [3:0] modeSel,
  input  logic [1:0] ptrA,
  input  logic [1:0] ptrB,
  input  logic       ovrEn,
  input  logic [1:0] ovrSel,
  output agu_ctrl_t  ctrl
);
  logic aBase, bBase, aIndex, bIndex, dataMode;

  always_comb begin
    aBase    = (ptrA == P_BX) || (ptrA == P_BP);
    bBase    = (ptrB == P_BX) || (ptrB == P_BP);
    aIndex   = !aBase;
    bIndex   = !bBase;
    dataMode = (modeSel >= M_DIRECT) && (modeSel <= M_BASEIDX);

    ctrl          = '0;
    ctrl.segId    = S_DS;
    case (modeSel)
      M_REG, M_IMM: ctrl.noAccess = 1'b1;
      M_DIRECT:     ctrl.useDisp  = 1'b1;
      M_INDIR: begin
        ctrl.useA    = 1'b1;
        ctrl.illegal = (ptrA == P_BP);
      end
      M_BASED: begin
        ctrl.useA    = 1'b1;
        ctrl.useDisp = 1'b1;
        ctrl.illegal = !aBase;
        if (ptrA == P_BP) ctrl.segId = S_SS;
      end
      M_INDEXED: begin
        ctrl.useA    = 1'b1;
        ctrl.useDisp = 1'b1;
        ctrl.illegal = !aIndex;
      end
      M_BASEIDX: begin
        ctrl.useA    = 1'b1;
        ctrl.useB    = 1'b1;
        ctrl.useDisp = 1'b1;
        ctrl.illegal = !((aBase && bIndex) || (aIndex && bBase));
        if ((ptrA == P_BP) || (ptrB == P_BP)) ctrl.segId = S_SS;
      end
      M_FETCH: begin
        ctrl.fromIp = 1'b1;
        ctrl.segId  = S_CS;
      end
      M_STACK: begin
        ctrl.fromSp = 1'b1;
        ctrl.segId  = S_SS;
      end
      default: ctrl.illegal = 1'b1;
    endcase

    if (ovrEn && dataMode) ctrl.segId = ovrSel;
  end
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  agu_ctrl_t                      ctrl,
  input  logic [OFF_W-1:0]               segCs,
  input  logic [OFF_W-1:0]               segDs,
  input  logic [OFF_W-1:0]               segEs,
  input  logic [OFF_W-1:0]               segSs,
  input  logic [OFF_W-1:0]               regBx,
  input  logic [OFF_W-1:0]               regBp,
  input  logic [OFF_W-1:0]               regSi,
  input  logic [OFF_W-1:0]               regDi,
  input  logic [OFF_W-1:0]               regIp,
  input  logic [OFF_W-1:0]               regSp,
  input  logic [OFF_W-1:0]               dispIn,
  input  logic                           dispShort,
  input  logic [1:0]                     ptrA,
  input  logic [1:0]                     ptrB,
  output logic [OFF_W-1:0]               effOffset,
  output logic [OFF_W-1:0]               segValue,
  output logic [OFF_W+SEG_SHIFT-1:0]     physAddr,
  output logic                           memValid
);
  localparam int PA_W = OFF_W + SEG_SHIFT;

  logic [OFF_W-1:0] opA, opB, shortExt, dispVal, offSum, segRaw;
  logic [PA_W-1:0]  paSum;

  generate
    if (SHORT_W < OFF_W) begin : g_sext
      assign shortExt = {{(OFF_W-SHORT_W){dispIn[SHORT_W-1]}}, dispIn[SHORT_W-1:0]};
    end else begin : g_full
      assign shortExt = dispIn;
    end
  endgenerate

  function automatic logic [OFF_W-1:0] pickPtr(input logic [1:0] sel,
      input logic [OFF_W-1:0] bx, bp, si, di);
    case (sel)
      P_BX:    return bx;
      P_BP:    return bp;
      P_SI:    return si;
      default: return di;
    endcase
  endfunction

  always_comb begin
    opA     = ctrl.useA ? pickPtr(ptrA, regBx, regBp, regSi, regDi) : '0;
    opB     = ctrl.useB ? pickPtr(ptrB, regBx, regBp, regSi, regDi) : '0;
    dispVal = !ctrl.useDisp ? '0 : (dispShort ? shortExt : dispIn);
    offSum  = opA + opB + dispVal
            + (ctrl.fromIp ? regIp : '0)
            + (ctrl.fromSp ? regSp : '0);
    case (ctrl.segId)
      S_CS:    segRaw = segCs;
      S_DS:    segRaw = segDs;
      S_ES:    segRaw = segEs;
      default: segRaw = segSs;
    endcase
    paSum     = {segRaw, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offSum};
    memValid  = !ctrl.illegal && !ctrl.noAccess;
    effOffset = memValid ? offSum : '0;
    segValue  = memValid ? segRaw : '0;
    physAddr  = memValid ? paSum  : '0;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import agu_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic [OFF_W-1:0]           segCs,
  input  logic [OFF_W-1:0]           segDs,
  input  logic [OFF_W-1:0]           segEs,
  input  logic [OFF_W-1:0]           segSs,
  input  logic [OFF_W-1:0]           regBx,
  input  logic [OFF_W-1:0]           regBp,
  input  logic [OFF_W-1:0]           regSi,
  input  logic [OFF_W-1:0]           regDi,
  input  logic [OFF_W-1:0]           regIp,
  input  logic [OFF_W-1:0]           regSp,
  input  logic [OFF_W-1:0]           dispIn,
  input  logic                       dispShort,
  input  logic [3:0]                 modeSel,
  input  logic [1:0]                 ptrA,
  input  logic [1:0]                 ptrB,
  input  logic                       ovrEn,
  input  logic [1:0]                 ovrSel,
  output logic [OFF_W-1:0]           effOffset,
  output logic [1:0]                 segUsed,
  output logic [OFF_W-1:0]           segValue,
  output logic [OFF_W+SEG_SHIFT-1:0] physAddr,
  output logic                       memValid,
  output logic                       noAccess,
  output logic                       illegal
);
  agu_ctrl_t ctrl;

  agu_ctrl u_ctrl (
    .modeSel(modeSel), .ptrA(ptrA), .ptrB(ptrB),
    .ovrEn(ovrEn), .ovrSel(ovrSel), .ctrl(ctrl)
  );

  agu_dpath #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .SHORT_W(SHORT_W)) u_dpath (
    .ctrl(ctrl),
    .segCs(segCs), .segDs(segDs), .segEs(segEs), .segSs(segSs),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .regIp(regIp), .regSp(regSp), .dispIn(dispIn), .dispShort(dispShort),
    .ptrA(ptrA), .ptrB(ptrB),
    .effOffset(effOffset), .segValue(segValue), .physAddr(physAddr),
    .memValid(memValid)
  );

  assign segUsed  = ctrl.segId;
  assign noAccess = ctrl.noAccess;
  assign illegal  = ctrl.illegal;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic [3:0]                 modeSel,
  input logic [1:0]                 ptrA,
  input logic [1:0]                 ptrB,
  input logic                       ovrEn,
  input logic [1:0]                 ovrSel,
  input logic [OFF_W-1:0]           regIp,
  input logic [OFF_W-1:0]           regSp,
  input logic [OFF_W-1:0]           effOffset,
  input logic [1:0]                 segUsed,
  input logic [OFF_W+SEG_SHIFT-1:0] physAddr,
  input logic                       memValid,
  input logic                       noAccess,
  input logic                       illegal
);
  always_comb begin
    p_one_flag_r12: assert ($onehot({memValid, noAccess, illegal}))
      else $error("flags not exclusive");
    p_illegal_zero_r11: assert (!illegal || (physAddr == '0 && effOffset == '0 && !memValid))
      else $error("illegal outputs not cleared");
    p_no_mem_r3: assert (!(modeSel < 4'd2) || noAccess)
      else $error("register/immediate formed an access");
    p_fetch_r9: assert (modeSel != 4'd7 || (memValid && segUsed == 2'd0 && effOffset == regIp))
      else $error("fetch not CS:IP");
    p_stack_r9: assert (modeSel != 4'd8 || (memValid && segUsed == 2'd3 && effOffset == regSp))
      else $error("stack not SS:SP");
    p_two_index_r7: assert (!(modeSel == 4'd6 && ptrA[1] && ptrB[1]) || illegal)
      else $error("SI+DI accepted");
    p_override_r10: assert (!(memValid && ovrEn && modeSel >= 4'd2 && modeSel <= 4'd6)
                            || segUsed == ovrSel)
      else $error("override ignored");
  end
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) chk_i (
  .modeSel(modeSel), .ptrA(ptrA), .ptrB(ptrB), .ovrEn(ovrEn), .ovrSel(ovrSel),
  .regIp(regIp), .regSp(regSp), .effOffset(effOffset), .segUsed(segUsed),
  .physAddr(physAddr), .memValid(memValid), .noAccess(noAccess), .illegal(illegal)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] segCs, segDs, segEs, segSs, regBx, regBp, regSi, regDi, regIp, regSp, dispIn;
  logic        dispShort, ovrEn;
  logic [3:0]  modeSel;
  logic [1:0]  ptrA, ptrB, ovrSel;
  logic [15:0] effOffset, segValue;
  logic [1:0]  segUsed;
  logic [19:0] physAddr;
  logic        memValid, noAccess, illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  seg_addr_gen dut_i (
    .segCs(segCs), .segDs(segDs), .segEs(segEs), .segSs(segSs),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .regIp(regIp), .regSp(regSp), .dispIn(dispIn), .dispShort(dispShort),
    .modeSel(modeSel), .ptrA(ptrA), .ptrB(ptrB), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .effOffset(effOffset), .segUsed(segUsed), .segValue(segValue),
    .physAddr(physAddr), .memValid(memValid), .noAccess(noAccess), .illegal(illegal)
  );

  function automatic logic [15:0] regOf(input logic [1:0] p);
    return (p == 0) ? regBx : (p == 1) ? regBp : (p == 2) ? regSi : regDi;
  endfunction

  function automatic logic [15:0] segOf(input logic [1:0] s);
    return (s == 0) ? segCs : (s == 1) ? segDs : (s == 2) ? segEs : segSs;
  endfunction

  function automatic string tagOf(input logic [3:0] m);
    case (m)
      0, 1: return "R3";
      2: return "R8";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic checkNow(input string tag);
    logic [15:0] d, off;
    logic [1:0]  sg;
    logic        v, n, bad;
    logic [19:0] pa;
    int unsigned sum;
    d   = dispShort ? {{8{dispIn[7]}}, dispIn[7:0]} : dispIn;
    sg  = 2'd1; n = 0; bad = 0; off = 0;
    case (modeSel)
      0, 1: n = 1;
      2: off = d;
      3: begin off = regOf(ptrA); bad = (ptrA == 1); end
      4: begin off = regOf(ptrA) + d; bad = ptrA[1]; if (ptrA == 1) sg = 3; end
      5: begin off = regOf(ptrA) + d; bad = !ptrA[1]; end
      6: begin
        off = regOf(ptrA) + regOf(ptrB) + d;
        bad = (ptrA[1] == ptrB[1]);
        if (ptrA == 1 || ptrB == 1) sg = 3;
      end
      7: begin off = regIp; sg = 0; end
      8: begin off = regSp; sg = 3; end
      default: bad = 1;
    endcase
    if (ovrEn && modeSel >= 2 && modeSel <= 6) sg = ovrSel;
    v   = !n && !bad;
    sum = ({16'd0, segOf(sg)} << 4) + {16'd0, off};
    pa  = v ? sum[19:0] : 20'd0;
    if (!v) off = 0;
    checks++;
    if (memValid !== v || noAccess !== n || illegal !== bad || effOffset !== off ||
        physAddr !== pa || (v && (segUsed !== sg || segValue !== segOf(sg))) ||
        (!v && segValue !== 16'd0)) begin
      fails++;
      $display("FAIL %s mode=%0d: got v%b n%b i%b off=%h seg=%0d segv=%h pa=%h exp v%b n%b i%b off=%h seg=%0d pa=%h",
               tag, modeSel, memValid, noAccess, illegal, effOffset, segUsed, segValue, physAddr,
               v, n, bad, off, sg, pa);
    end
  endtask

  task automatic zeroIn();
    {segCs, segDs, segEs, segSs, regBx, regBp, regSi, regDi, regIp, regSp, dispIn} = '0;
    dispShort = 0; ovrEn = 0; ovrSel = 0; modeSel = 0; ptrA = 0; ptrB = 0;
  endtask

  task automatic step(input string tag);
    #5;
    checkNow(tag);
    @(negedge clk);
  endtask

  initial begin
    zeroIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    step("R3 reset state");

    // R1 wrap past top of memory, fetch path
    segCs = 16'hFF59; regIp = 16'hFFFF; modeSel = 7; step("R1 R9 wrap");
    if (physAddr !== 20'h0F58F) begin fails++; $display("FAIL R1 pa=%h exp 0F58F", physAddr); end
    // R9 fetch ignores override and displacement
    ovrEn = 1; ovrSel = 2; dispIn = 16'h1234; step("R9 fetch override");
    regSp = 16'hFFFE; segSs = 16'h3500; modeSel = 8; step("R9 stack");
    ovrEn = 0;
    // R2 offset wrap and short displacement
    segDs = 16'h4500; regBx = 16'hFFFF; dispIn = 16'h0002; modeSel = 4; ptrA = 0; step("R2 offset wrap");
    regBx = 16'h2100; dispIn = 16'h0080; dispShort = 1; step("R2 short disp");
    dispShort = 0; dispIn = 16'h0020; step("R5 BX+disp");
    segSs = 16'h2000; regBp = 16'h7814; dispIn = 16'h12; ptrA = 1; step("R5 BP->SS");
    ptrA = 2; step("R5 SI illegal");
    // R10 override on BP-based
    segCs = 16'h1111; ptrA = 1; ovrEn = 1; ovrSel = 0; step("R10 BP with CS override");
    ovrEn = 0;
    // R4 / R6 / R8
    modeSel = 3; ptrA = 1; step("R4 BP illegal");
    regSi = 16'h2498; segDs = 16'h1120; ptrA = 2; step("R4 SI");
    modeSel = 5; ptrA = 0; step("R6 BX illegal");
    regDi = 16'h8500; ptrA = 3; dispIn = 4; step("R6 DI");
    segDs = 16'h1512; dispIn = 16'h3518; modeSel = 2; step("R8 direct");
    // R7 orderings and illegal pairs
    modeSel = 6; ptrA = 0; ptrB = 3; dispIn = 8; step("R7 BX+DI");
    ptrA = 3; ptrB = 0; step("R7 DI+BX swapped");
    ptrA = 2; ptrB = 1; step("R7 SI+BP SS");
    ptrA = 2; ptrB = 3; step("R7 SI+DI illegal");
    ptrA = 0; ptrB = 1; step("R7 BX+BP illegal");
    // R11 undefined codes
    for (int m = 9; m < 16; m++) begin modeSel = m[3:0]; step("R11 bad mode"); end

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      segCs = $urandom; segDs = $urandom; segEs = $urandom; segSs = $urandom;
      regBx = $urandom; regBp = $urandom; regSi = $urandom; regDi = $urandom;
      regIp = $urandom; regSp = $urandom; dispIn = $urandom;
      dispShort = $urandom % 2; ovrEn = ($urandom % 3) == 0; ovrSel = $urandom % 4;
      modeSel = (($urandom % 10) == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      ptrA = $urandom % 4; ptrB = $urandom % 4;
      step(ovrEn ? "R10 random" : tagOf(modeSel));
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule